// File: doc/BRIEF.md
# Subroutine Return Address Stack

This block keeps subroutine return addresses in a small hardware last-in, first-out store instead of in an ordinary register. Architectural register x1 is mapped onto this store. Any jump that names x1 as its destination pushes a return address. A register-indirect jump that names x1 as its source pops an address. Because of this, nested calls and returns unwind in hardware with no spill code.

The block sees one decoded jump per cycle. For each jump it receives the operation class, the destination and source register numbers, the current program counter, the immediate offset and the general-register read value. It returns the jump target, with the popped entry used as the base whenever x1 is the source. It also presents the current top entry as the x1 read value. A push onto a full store and a pop from an empty store are each reported on an error output in the following cycle. The register file, the other registers and fetch redirection are outside this block.

Top module: `ret_stack`

## Requirements
- R1: After reset the store is empty, `x1_rdata_o` reads 0, and both error outputs are low.
- R2: When a valid direct jump (`op_class_i` = 2'b01) has `rd_i` = 1, it pushes `pc_i + 4`. From the next cycle, `x1_rdata_o` shows that value.
- R3: When a valid indirect jump (`op_class_i` = 2'b10) has `rd_i` = 1 and `rs1_i` not equal to 1, `target_o` is `rs1_rdata_i + imm_i` in the same cycle, and the jump pushes `pc_i + 4`.
- R4: When a valid indirect jump has `rs1_i` = 1, it pops the top entry. `target_o` is that old top plus `imm_i` in the same cycle, and `x1_rdata_o` then shows the entry below it, or 0 if none remains.
- R5: A valid jump whose `rd_i` is not 1 (for example x0) pushes nothing, and its link value is discarded.
- R6: A valid indirect jump with `rd_i` = 1 and `rs1_i` = 1 pops before it pushes. Its target is the old top plus `imm_i`, the occupancy is unchanged, the new top is `pc_i + 4`, and this raises no overflow even when the store is full.
- R7: A push when the store holds DEPTH entries leaves the store unchanged and raises `overflow_o` for exactly the next cycle. `overflow_o` and `underflow_o` are never high together.
- R8: A pop from an empty store uses 0 as the jump base, leaves the store unchanged (apart from any push in the same instruction), and raises `underflow_o` for exactly the next cycle.
- R9: The store does not change when `instr_valid_i` is low, or when `op_class_i` is 2'b00 or 2'b11.
- R10: For a valid direct jump, `target_o` is `pc_i + imm_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| instr_valid_i | input | 1 | A decoded instruction is present this cycle |
| op_class_i | input | 2 | 00 other, 01 direct jump, 10 indirect jump, 11 reserved (treated as other) |
| rd_i | input | 5 | Destination register number |
| rs1_i | input | 5 | Source register number |
| pc_i | input | XLEN | Address of the current instruction |
| imm_i | input | XLEN | Sign-extended offset |
| rs1_rdata_i | input | XLEN | General-register value of the source when it is not x1 |
| x1_rdata_o | output | XLEN | Current top entry, 0 when empty |
| target_o | output | XLEN | Jump target for the current instruction |
| overflow_o | output | 1 | Push onto a full store, one cycle after the instruction |
| underflow_o | output | 1 | Pop from an empty store, one cycle after the instruction |

## Verification
A wrong occupancy count appears in two ways. The cycle after the faulty update, `x1_rdata_o` shows a stale or missing entry. At the next return, `target_o` is wrong in the same cycle as the return. Error flags that appear one level early or late expose an off-by-one in the full or empty comparison at the very next push or pop. A wrong pop-before-push order shows on a combined x1-to-x1 jump, either as an overflow on a full store or as a changed depth on the following pops. The bench fills a depth-4 store to every level and applies each jump kind at each level. It then runs a long random sequence against an arithmetic model, comparing the target combinationally before each edge and the top value and the flags after it.

// File: rtl/ret_stack_pkg.sv
package ret_stack_pkg;
  localparam int RegW = 5;
  localparam logic [RegW-1:0] LinkReg = 5'd1;

  typedef enum logic [1:0] {
    OP_OTHER = 2'b00,
    OP_JUMP  = 2'b01,
    OP_JUMPR = 2'b10,
    OP_RSVD  = 2'b11
  } op_class_e;
endpackage

// File: rtl/ret_stack_decode.sv
module ret_stack_decode
  import ret_stack_pkg::*;
(
  input  logic            valid_i,
  input  logic [1:0]      op_class_i,
  input  logic [RegW-1:0] rd_i,
  input  logic [RegW-1:0] rs1_i,
  output logic            push_o,
  output logic            pop_o,
  output logic            direct_o,
  output logic            src_link_o
);
  op_class_e op;
  logic      is_jump;
  logic      is_jumpr;

  always_comb begin
    op         = op_class_e'(op_class_i);
    is_jump    = valid_i && (op == OP_JUMP);
    is_jumpr   = valid_i && (op == OP_JUMPR);
    src_link_o = (rs1_i == LinkReg);
    direct_o   = (op == OP_JUMP);
    push_o     = (is_jump || is_jumpr) && (rd_i == LinkReg);
    pop_o      = is_jumpr && src_link_o;
  end
endmodule

// File: rtl/ret_stack_target.sv
module ret_stack_target #(
  parameter int XLEN     = 32,
  parameter int LINK_INC = 4
) (
  input  logic            direct_i,
  input  logic            src_link_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] imm_i,
  input  logic [XLEN-1:0] rs1_rdata_i,
  input  logic [XLEN-1:0] top_i,
  output logic [XLEN-1:0] target_o,
  output logic [XLEN-1:0] link_o
);
  logic [XLEN-1:0] base;

  always_comb begin
    if (direct_i)        base = pc_i;
    else if (src_link_i) base = top_i;
    else                 base = rs1_rdata_i;
    target_o = base + imm_i;
    link_o   = pc_i + XLEN'(LINK_INC);
  end
endmodule

// File: rtl/ret_stack_lifo.sv
module ret_stack_lifo #(
  parameter int XLEN  = 32,
  parameter int DEPTH = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic            pop_i,
  input  logic [XLEN-1:0] push_data_i,
  output logic [XLEN-1:0] top_o,
  output logic            overflow_o,
  output logic            underflow_o
);
  localparam int CntW = $clog2(DEPTH + 1);
  localparam int IdxW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CntW-1:0] Full = CntW'(DEPTH);

  logic [CntW-1:0]  cnt_q, cnt_d, cnt_mid, top_ptr;
  logic             cnt_en, empty, pop_ok, push_ok, ovf_d, unf_d;
  logic             ovf_q, unf_q;
  logic [DEPTH-1:0] wr_en;
  logic [XLEN-1:0]  mem_q [DEPTH];

  // Pop is resolved first so that a combined pop and push sees the freed slot.
  always_comb begin
    empty   = (cnt_q == '0);
    pop_ok  = pop_i && !empty;
    unf_d   = pop_i && empty;
    cnt_mid = cnt_q - CntW'(pop_ok);
    push_ok = push_i && (cnt_mid != Full);
    ovf_d   = push_i && !push_ok;
    cnt_d   = cnt_mid + CntW'(push_ok);
    cnt_en  = pop_ok || push_ok;
    top_ptr = cnt_q - CntW'(1);
    top_o   = empty ? '0 : mem_q[top_ptr[IdxW-1:0]];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    assign wr_en[g] = push_ok && (cnt_mid == CntW'(g));
    always_ff @(posedge clk_i) begin
      if (wr_en[g]) begin
        mem_q[g] <= push_data_i;
      end
    end
  end

  assign overflow_o  = ovf_q;
  assign underflow_o = unf_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= Full) // R7
    else $error("occupancy above depth");
  AST_OVF_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_d |=> ($stable(cnt_q) && overflow_o)) // R7
    else $error("overflow changed the store");
  AST_UNF_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unf_d && !push_i) |=> ($stable(cnt_q) && underflow_o)) // R8
    else $error("underflow changed the store");
  AST_PUSH_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_ok |=> (top_o == $past(push_data_i))) // R2
    else $error("pushed value not on top");
  AST_SWAP_DEPTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && push_i && !empty) |=> ($stable(cnt_q) && !overflow_o)) // R6
    else $error("combined pop and push changed depth");
endmodule

// File: rtl/ret_stack.sv
module ret_stack
  import ret_stack_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int DEPTH = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            instr_valid_i,
  input  logic [1:0]      op_class_i,
  input  logic [4:0]      rd_i,
  input  logic [4:0]      rs1_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] imm_i,
  input  logic [XLEN-1:0] rs1_rdata_i,
  output logic [XLEN-1:0] x1_rdata_o,
  output logic [XLEN-1:0] target_o,
  output logic            overflow_o,
  output logic            underflow_o
);
  logic            push, pop, direct, src_link;
  logic [XLEN-1:0] top, link;

  ret_stack_decode u_decode (
    .valid_i    (instr_valid_i),
    .op_class_i (op_class_i),
    .rd_i       (rd_i),
    .rs1_i      (rs1_i),
    .push_o     (push),
    .pop_o      (pop),
    .direct_o   (direct),
    .src_link_o (src_link)
  );

  ret_stack_target #(.XLEN(XLEN), .LINK_INC(4)) u_target (
    .direct_i    (direct),
    .src_link_i  (src_link),
    .pc_i        (pc_i),
    .imm_i       (imm_i),
    .rs1_rdata_i (rs1_rdata_i),
    .top_i       (top),
    .target_o    (target_o),
    .link_o      (link)
  );

  ret_stack_lifo #(.XLEN(XLEN), .DEPTH(DEPTH)) u_lifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .pop_i       (pop),
    .push_data_i (link),
    .top_o       (top),
    .overflow_o  (overflow_o),
    .underflow_o (underflow_o)
  );

  assign x1_rdata_o = top;

  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_valid_i |=> $stable(x1_rdata_o)) // R9
    else $error("store moved without an instruction");
  AST_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(overflow_o && underflow_o)) // R7
    else $error("both error flags high");
  AST_NO_PUSH_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i != LinkReg && !pop) |=> $stable(x1_rdata_o)) // R5
    else $error("non-link destination changed the store");
endmodule

// File: tb/ret_stack_bench.sv
`timescale 1ns/1ps
module ret_stack_bench;
  localparam int XLEN  = 32;
  localparam int DEPTH = 4;

  logic            clk = 1'b0;
  logic            rst_ni;
  logic            instr_valid_i;
  logic [1:0]      op_class_i;
  logic [4:0]      rd_i, rs1_i;
  logic [XLEN-1:0] pc_i, imm_i, rs1_rdata_i;
  logic [XLEN-1:0] x1_rdata_o, target_o;
  logic            overflow_o, underflow_o;

  int checks = 0;
  int errors = 0;
  logic [XLEN-1:0] mdl [DEPTH];
  int mcnt = 0;

  always #2.5 clk = ~clk;

  ret_stack #(.XLEN(XLEN), .DEPTH(DEPTH)) u_ret_stack (
    .clk_i(clk), .rst_ni(rst_ni), .instr_valid_i(instr_valid_i),
    .op_class_i(op_class_i), .rd_i(rd_i), .rs1_i(rs1_i), .pc_i(pc_i),
    .imm_i(imm_i), .rs1_rdata_i(rs1_rdata_i), .x1_rdata_o(x1_rdata_o),
    .target_o(target_o), .overflow_o(overflow_o), .underflow_o(underflow_o)
  );

  task automatic chk(input string tag, input logic [XLEN-1:0] act,
                     input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [XLEN-1:0] mtop();
    return (mcnt > 0) ? mdl[mcnt-1] : '0;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; instr_valid_i = 1'b0; op_class_i = 2'b00;
    rd_i = '0; rs1_i = '0; pc_i = '0; imm_i = '0; rs1_rdata_i = '0;
    mcnt = 0;
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk("R1 top", x1_rdata_o, '0);
    chk("R1 ovf", {31'd0, overflow_o}, '0);
    chk("R1 unf", {31'd0, underflow_o}, '0);
  endtask

  task automatic step(input logic v, input logic [1:0] op, input logic [4:0] rd,
                      input logic [4:0] rs1, input logic [XLEN-1:0] pc,
                      input logic [XLEN-1:0] imm, input logic [XLEN-1:0] rsd);
    logic jal, jalr, push, pop, of, uf;
    logic [XLEN-1:0] exp_t;
    string tag;
    @(negedge clk);
    instr_valid_i = v; op_class_i = op; rd_i = rd; rs1_i = rs1;
    pc_i = pc; imm_i = imm; rs1_rdata_i = rsd;
    jal  = v && (op == 2'b01);
    jalr = v && (op == 2'b10);
    push = (jal || jalr) && (rd == 5'd1);
    pop  = jalr && (rs1 == 5'd1);
    #1;
    if (jal) chk("R10 target", target_o, pc + imm);
    if (jalr) begin
      exp_t = ((rs1 == 5'd1) ? mtop() : rsd) + imm;
      if (rs1 != 5'd1)   chk("R3 target", target_o, exp_t);
      else if (mcnt == 0) chk("R8 target", target_o, exp_t);
      else if (push)     chk("R6 target", target_o, exp_t);
      else               chk("R4 target", target_o, exp_t);
    end
    uf = pop && (mcnt == 0);
    if (pop && mcnt > 0) mcnt--;
    of = push && (mcnt == DEPTH);
    if (push && !of) begin
      mdl[mcnt] = pc + 32'd4;
      mcnt++;
    end
    if (push && pop)      tag = "R6 top";
    else if (of)          tag = "R7 top";
    else if (push && jal) tag = "R2 top";
    else if (push)        tag = "R3 top";
    else if (uf)          tag = "R8 top";
    else if (pop)         tag = "R4 top";
    else if (jal || jalr) tag = "R5 top";
    else                  tag = "R9 top";
    @(posedge clk);
    #1;
    chk(tag, x1_rdata_o, mtop());
    chk("R7 overflow", {31'd0, overflow_o}, {31'd0, of});
    chk("R8 underflow", {31'd0, underflow_o}, {31'd0, uf});
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // Every fill level crossed with every jump kind.
    for (int lvl = 0; lvl <= DEPTH; lvl++) begin
      for (int kind = 0; kind < 8; kind++) begin
        do_reset();
        for (int k = 0; k < lvl; k++)
          step(1'b1, 2'b01, 5'd1, 5'd0, 32'h100 + 32'(k) * 16, 32'h40, '0);
        case (kind)
          0: step(1'b1, 2'b10, 5'd0, 5'd1, 32'h900, 32'd0, 32'hdead);     // R4 return
          1: step(1'b1, 2'b10, 5'd1, 5'd7, 32'h904, 32'h8, 32'h3000);      // R3 call via pointer
          2: step(1'b1, 2'b10, 5'd1, 5'd1, 32'h908, 32'hfffffffc, '0);     // R6 swap
          3: step(1'b1, 2'b01, 5'd0, 5'd0, 32'h90c, 32'h20, '0);           // R5 discard to x0
          4: step(1'b0, 2'b01, 5'd1, 5'd1, 32'h910, 32'h20, '0);           // R9 invalid
          5: step(1'b1, 2'b11, 5'd1, 5'd1, 32'h914, 32'h20, '0);           // R9 reserved class
          6: step(1'b1, 2'b01, 5'd1, 5'd0, 32'h918, 32'hffffff00, '0);     // R2 call
          default: step(1'b1, 2'b00, 5'd1, 5'd1, 32'h91c, 32'h4, '0);     // R9 other op
        endcase
        for (int k = 0; k <= DEPTH; k++)
          step(1'b1, 2'b10, 5'd0, 5'd1, 32'ha00, 32'd0, '0);              // R4/R8 drain
      end
    end
    // Long mixed sequence against the model.
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] | r[1], r[3:2], (r[5:4] == 2'b00) ? 5'd0 : (r[6] ? 5'd1 : 5'd5),
           (r[8:7] == 2'b00) ? 5'd3 : 5'd1, {r[31:12], 2'b00},
           {{24{r[11]}}, r[11:9], 5'b0}, $urandom);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule